// File: doc/BRIEF.md
# Strobe Activity Watchdog

This block watches a heartbeat line driven by a processor and raises a one-cycle expiry pulse toward the reset sequencer when the line has shown no high-to-low transition for a chosen number of clock cycles. Only falling transitions count as a sign of life. A line stuck high or stuck low, or one that only rises, therefore times out just as an idle line does.

The timeout comes from a two-bit select that has already been decoded from a three-state strapping pin: short, medium (pin floating) and long. The three lengths are parameters given in clock cycles. The defaults correspond to roughly 150 ms, 600 ms and 1.2 s at 125 MHz. The strobe crosses into the clock domain through a two-flop synchronizer. After each expiry the count starts again, so an idle line produces a pulse train with a period equal to the timeout. The block has no stream interface: every pin is a plain level or pulse with no valid/ready handshake and no back-pressure.

Top module: `strobe_watchdog`

## Requirements
- R1: A high-to-low transition of `strobe_i` restarts the count. The strobe passes two synchronizer flops and one history flop, so the count is zero after the third rising clock edge that samples the new low level. The next expiry then follows L edges later, where L is the selected timeout.
- R2: Rising transitions and steady levels of `strobe_i` never restart the count. A line held high or held low expires every L cycles.
- R3: Select code 2'b00 picks `SHORT_TICKS`, 2'b01 picks `MID_TICKS`, 2'b10 picks `LONG_TICKS`, and 2'b11 behaves exactly like 2'b01.
- R4: `expired_o` is high for exactly one cycle, at the L-th rising edge after the last restart. The count then starts over, so pulses repeat every L cycles while no restart arrives.
- R5: A change of the decoded select setting restarts the count at the next rising edge, and the new timeout applies from then on. Moving between 2'b01 and 2'b11 is not a change.
- R6: While `rst` is high, `expired_o` is low and the count is held at zero. The first expiry comes L edges after the last edge that sampled `rst` high.
- R7: When a restart (strobe fall or select change) lands on the same edge at which the count would expire, the restart wins and no pulse is produced.
- R8: A low pulse on `strobe_i` that lasts one clock period and spans a rising edge is recognised as a falling transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_i | input | 1 | Asynchronous heartbeat line from the processor |
| tsel_i | input | 2 | Timeout select: 00 short, 01 medium, 10 long, 11 medium |
| expired_o | output | 1 | One-cycle pulse when the timeout elapses |

## Verification
Expiry and restart can fall on the same edge. That happens when a synchronized falling edge, or a select change, reaches the counter on the edge that would otherwise produce the pulse. The bench provokes both cases by timing a strobe fall three cycles before a predicted pulse, and a select change one cycle before one. It judges them by removing that pulse from its expected schedule and placing the next one a full new period after the restart, so any stray or late pulse shows up as a mismatch.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    TSEL_SHORT = 2'd0,
    TSEL_MID   = 2'd1,
    TSEL_LONG  = 2'd2
  } tsel_e;

  // Code 2'b11 folds onto the medium setting.
  function automatic tsel_e tsel_decode(input logic [1:0] code);
    tsel_e m;
    case (code)
      2'b00:   m = TSEL_SHORT;
      2'b10:   m = TSEL_LONG;
      default: m = TSEL_MID;
    endcase
    return m;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];

endmodule

// File: rtl/wdt_fall_detect.sv
module wdt_fall_detect (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic fall_o
);

  logic hist_q;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= level_i;
  end

  assign fall_o = hist_q & ~level_i;

  // R2
  rise_not_fall_chk: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
  import wdt_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 16,
  parameter int unsigned MID_TICKS   = 64,
  parameter int unsigned LONG_TICKS  = 128,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       tsel_i,
  output logic [CNT_W-1:0] limit_o,
  output logic             change_o
);

  tsel_e mode_d, mode_q;

  assign mode_d = tsel_decode(tsel_i);

  // Sampled during reset too, so release never looks like a change.
  always_ff @(posedge clk) begin
    mode_q <= mode_d;
  end

  always_comb begin
    case (mode_d)
      TSEL_SHORT: limit_o = CNT_W'(SHORT_TICKS);
      TSEL_LONG:  limit_o = CNT_W'(LONG_TICKS);
      default:    limit_o = CNT_W'(MID_TICKS);
    endcase
  end

  assign change_o = (mode_q != mode_d);

  // R3
  fold_code_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel_i == 2'b11) |-> (limit_o == CNT_W'(MID_TICKS)));

  // R5
  alias_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(tsel_i) == 2'b01 && tsel_i == 2'b11) |-> !change_o);

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit = (cnt_q >= limit_i - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else if (restart_i) begin
      cnt_q     <= '0;
      expired_o <= 1'b0;
    end else if (hit) begin
      cnt_q     <= '0;
      expired_o <= 1'b1;
    end else begin
      cnt_q     <= cnt_q + CNT_W'(1);
      expired_o <= 1'b0;
    end
  end

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    expired_o |=> !expired_o);

  // R7
  restart_wins_chk: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !expired_o);

  // R5
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= limit_i) |-> restart_i);

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog
  import wdt_pkg::*;
#(
  parameter int unsigned SHORT_TICKS = 18_750_000,
  parameter int unsigned MID_TICKS   = 75_000_000,
  parameter int unsigned LONG_TICKS  = 150_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_i,
  input  logic [1:0] tsel_i,
  output logic       expired_o
);

  localparam int unsigned MAX_TICKS = max3(SHORT_TICKS, MID_TICKS, LONG_TICKS);
  localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);

  logic             strobe_s;
  logic             fall;
  logic             sel_change;
  logic             restart;
  logic [CNT_W-1:0] limit;
  logic [1:0]       age_q;

  initial begin
    if (SHORT_TICKS < 2 || MID_TICKS < 2 || LONG_TICKS < 2)
      $error("timeouts must be at least two cycles");
  end

  wdt_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (strobe_i),
    .q_o (strobe_s)
  );

  wdt_fall_detect u_fall (
    .clk     (clk),
    .rst     (rst),
    .level_i (strobe_s),
    .fall_o  (fall)
  );

  wdt_period_sel #(
    .SHORT_TICKS (SHORT_TICKS),
    .MID_TICKS   (MID_TICKS),
    .LONG_TICKS  (LONG_TICKS),
    .CNT_W       (CNT_W)
  ) u_psel (
    .clk      (clk),
    .rst      (rst),
    .tsel_i   (tsel_i),
    .limit_o  (limit),
    .change_o (sel_change)
  );

  assign restart = fall | sel_change;

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart),
    .limit_i   (limit),
    .expired_o (expired_o)
  );

  // Cycles since reset release, saturating; used only to qualify checks.
  always_ff @(posedge clk) begin
    if (rst)               age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R1
  fall_seen_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3 && SYNC_STAGES == 2 && $past(strobe_i, 3) && !$past(strobe_i, 2))
      |-> fall);

  // R2
  rise_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == 2'd3 && SYNC_STAGES == 2 && !$past(strobe_i, 3) && $past(strobe_i, 2))
      |-> !fall);

endmodule

// File: tb/strobe_watchdog_tb.sv
module strobe_watchdog_tb;

  localparam int unsigned T_SHORT = 20;
  localparam int unsigned T_MID   = 50;
  localparam int unsigned T_LONG  = 90;
  localparam int          WDOG    = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       strobe_i = 1'b1;
  logic [1:0] tsel_i = 2'b00;
  logic       expired_o;

  int compared   = 0;
  int mismatched = 0;
  int cyc        = 0;
  bit done       = 1'b0;

  int    q_cyc[$];
  string q_req[$];
  int    nxt = 1 << 30;
  int    per = T_SHORT;
  string tag = "R6";

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  strobe_watchdog #(
    .SHORT_TICKS (T_SHORT),
    .MID_TICKS   (T_MID),
    .LONG_TICKS  (T_LONG)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .strobe_i  (strobe_i),
    .tsel_i    (tsel_i),
    .expired_o (expired_o)
  );

  function automatic int period_of(input logic [1:0] s);
    case (s)
      2'b00:   return T_SHORT;
      2'b10:   return T_LONG;
      default: return T_MID;
    endcase
  endfunction

  task automatic push_until(input int lim);
    while (nxt <= lim) begin
      q_cyc.push_back(nxt);
      q_req.push_back(tag);
      nxt += per;
    end
  endtask

  task automatic hold(input int n);
    push_until(cyc + n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart_at(input int e, input int p);
    push_until(e - 1);
    per = p;
    nxt = e + p;
  endtask

  task automatic check_quiet(input string req);
    compared++;
    if (expired_o !== 1'b0) begin
      mismatched++;
      $display("FAIL %s: expired_o during reset actual=%b expected=0", req, expired_o);
    end
  endtask

  task automatic do_reset(input int n);
    push_until(cyc);
    nxt = 1 << 30;
    rst = 1'b1;
    repeat (n) @(negedge clk);
    check_quiet("R6");
    rst = 1'b0;
    per = period_of(tsel_i);
    nxt = cyc + per;
  endtask

  // Monitor: pops predicted pulse cycles and compares them with observed ones.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
        compared++;
        mismatched++;
        $display("FAIL %s: pulse missing actual=none expected=cycle %0d", q_req[0], q_cyc[0]);
        void'(q_cyc.pop_front());
        void'(q_req.pop_front());
      end
      if (expired_o === 1'b1) begin
        compared++;
        if (q_cyc.size() == 0 || q_cyc[0] != cyc) begin
          mismatched++;
          $display("FAIL R4: unexpected pulse actual=cycle %0d expected=%0d", cyc,
                   (q_cyc.size() > 0) ? q_cyc[0] : -1);
        end else begin
          void'(q_cyc.pop_front());
          void'(q_req.pop_front());
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  // Driver
  initial begin
    @(negedge clk);
    repeat (4) @(negedge clk);
    check_quiet("R6");                  // reset state
    rst = 1'b0;
    per = T_SHORT;
    nxt = cyc + per;                    // R6: first pulse L edges after reset

    tag = "R6"; hold(25);
    tag = "R2"; hold(45);               // stuck high

    tag = "R1";                         // falling edge restarts
    restart_at(cyc + 3, per);
    strobe_i = 1'b0;
    hold(25);
    tag = "R2"; hold(45);               // stuck low

    tag = "R2"; strobe_i = 1'b1;        // rising edge ignored
    hold(50);

    tag = "R8";                         // one-cycle low pulse
    restart_at(cyc + 3, per);
    strobe_i = 1'b0;
    hold(1);
    strobe_i = 1'b1;
    hold(45);

    tag = "R5";                         // select change, medium
    restart_at(cyc + 1, T_MID);
    tsel_i = 2'b01;
    hold(120);

    tag = "R3";                         // 11 aliases medium, no restart
    tsel_i = 2'b11;
    hold(120);

    tag = "R3";                         // long
    restart_at(cyc + 1, T_LONG);
    tsel_i = 2'b10;
    hold(200);

    tag = "R3";                         // 11 from long: medium, restart
    restart_at(cyc + 1, T_MID);
    tsel_i = 2'b11;
    hold(110);

    tag = "R7";                         // fall lands on expiry edge
    while (nxt - cyc < 3) hold(1);
    hold(nxt - 3 - cyc);
    restart_at(cyc + 3, per);
    strobe_i = 1'b0;
    hold(40);
    strobe_i = 1'b1;
    hold(10);

    tag = "R7";                         // select change lands on expiry edge
    while (nxt - cyc < 1) hold(1);
    hold(nxt - 1 - cyc);
    restart_at(cyc + 1, T_SHORT);
    tsel_i = 2'b00;
    hold(60);

    tag = "R6";                         // mid-run reset
    do_reset(4);
    hold(50);

    hold(3);
    compared++;
    if (q_cyc.size() != 0) begin
      mismatched++;
      $display("FAIL R4: pending pulses actual=%0d expected=0", q_cyc.size());
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule